// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external SPI master read and write a small file of sixteen byte-wide registers. The SPI pins are first brought into the system clock domain, and all decoding then runs in that domain. The system clock must be at least eight times faster than SCK. Each transaction opens with a command byte that holds the register address in its low nibble and the access type in its two top bits. One or two data bytes follow that command byte, and they reach the addressed register and the one after it.

The slave shows the current register contents on MISO during every data byte, including during writes, so a write returns the values held before the write. The pin drives only while chip select is low. Outside a transaction the output enable is low, and a pad outside the block uses it to tristate the line. Logic on the chip reads any register through a combinational read port.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset every register holds 0x00 and `miso_oe` is low.
- R2: Command byte bits [3:0] select the register. Bits [7:6] equal to 00 mark a write.
- R3: In a write, the first data byte goes to reg[a] and the second goes to reg[a+1]. a+1 wraps from 15 to 0. A transaction with a single data byte changes only reg[a].
- R4: A command whose bits [7:6] are not 00 never changes a register. This covers 0x4x and 0xCx (reads) and 0x8x.
- R5: While the command byte is shifted, MISO carries 0xFF.
- R6: During data byte 1, MISO carries reg[a]. During data byte 2, it carries reg[a+1]. For writes these are the values held before the write.
- R7: The fourth and later bytes of a transaction write nothing and return 0x00 on MISO.
- R8: A falling chip select raises `miso_oe` and restarts at the command byte, even after an aborted byte. A rising chip select lowers `miso_oe`.
- R9: SCK and MOSI activity while chip select is high changes no register and leaves `miso_oe` low.
- R10: The SPI mode is 0 with MSB first. MOSI is sampled on the rising edge of SCK, and MISO changes after the falling edge of SCK.
- R11: `int_rdata` shows reg[`int_addr`] without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| cs_n | input | 1 | Active-low chip select |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for the MISO pad; low means high impedance |
| int_addr | input | ADDR_W | Register index for the on-chip read port |
| int_rdata | output | 8 | Contents of the register selected by `int_addr` |

## Verification
Every pin passes through two synchronizer flops and then one decision register. A change on SCK or chip select therefore shows up on `miso`, `miso_oe` or a register three system clocks later, which is 15 ns. The bench holds each SCK phase for 40 ns, eight clocks. It samples MISO just before each rising edge and reads the internal port 40 ns after setting the address. Each sample therefore falls well after its result has settled, and well before the next stimulus. Stimulus changes 1 ns off the clock grid, so no sample coincides with a clock edge.

// File: rtl/spi_regfile_slave.sv
`timescale 1ns/1ps
module spi_regfile_slave #(
  parameter int ADDR_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              cs_n,
  output logic              miso,
  output logic              miso_oe,
  input  logic [ADDR_W-1:0] int_addr,
  output logic [7:0]        int_rdata
);
  localparam int NREG = 1 << ADDR_W;

  logic [SYNC_N-1:0] sck_q, mosi_q, cs_q;
  logic sck_d, cs_d;
  logic [NREG-1:0][7:0] regs;
  logic [ADDR_W-1:0] addr;
  logic is_wr, sel, pend;
  logic [2:0] bit_cnt;
  logic [1:0] byte_cnt;
  logic [6:0] shin;
  logic [7:0] shout, nxt;

  wire sck_s  = sck_q[SYNC_N-1];
  wire mosi_s = mosi_q[SYNC_N-1];
  wire cs_s   = cs_q[SYNC_N-1];
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire cs_fall  = ~cs_s & cs_d;
  wire cs_rise  = cs_s & ~cs_d;
  wire [7:0] rx_byte = {shin, mosi_s};
  wire [ADDR_W-1:0] addr_n = ADDR_W'(addr + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      cs_q   <= '1;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_q  <= {sck_q[SYNC_N-2:0], sck};
      mosi_q <= {mosi_q[SYNC_N-2:0], mosi};
      cs_q   <= {cs_q[SYNC_N-2:0], cs_n};
      sck_d  <= sck_s;
      cs_d   <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs     <= '0;
      addr     <= '0;
      is_wr    <= 1'b0;
      sel      <= 1'b0;
      pend     <= 1'b0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shin     <= '0;
      shout    <= '1;
      nxt      <= '0;
    end else if (cs_fall) begin
      sel      <= 1'b1;
      pend     <= 1'b0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shout    <= '1;
    end else if (cs_rise) begin
      sel <= 1'b0;
    end else if (sel) begin
      if (sck_rise) begin
        shin    <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          pend <= 1'b1;
          if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
          case (byte_cnt)
            2'd0: begin
              addr  <= rx_byte[ADDR_W-1:0];
              is_wr <= (rx_byte[7:6] == 2'b00);
              nxt   <= regs[rx_byte[ADDR_W-1:0]];
            end
            2'd1: begin
              if (is_wr) regs[addr] <= rx_byte;
              nxt <= regs[addr_n];
            end
            2'd2: begin
              if (is_wr) regs[addr_n] <= rx_byte;
              nxt <= '0;
            end
            default: nxt <= '0;
          endcase
        end
      end else if (sck_fall) begin
        if (pend) begin
          shout <= nxt;
          pend  <= 1'b0;
        end else begin
          shout <= {shout[6:0], 1'b0};
        end
      end
    end
  end

  assign miso      = shout[7];
  assign miso_oe   = sel;
  assign int_rdata = regs[int_addr];
endmodule

module spi_regfile_slave_chk #(
  parameter int ADDR_W = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           cs_s,
  input logic                           cs_d,
  input logic                           sel,
  input logic                           oe,
  input logic                           miso,
  input logic [1:0]                     byte_cnt,
  input logic [(1<<ADDR_W)-1:0][7:0]    regs
);
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && !cs_d) |=> !oe);
  a_r5_drive_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && cs_d) |=> (oe && miso));
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && cs_d) |=> (byte_cnt == 2'd0));
  a_r9_idle_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(regs));
  a_r9_idle_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_d) |-> !oe);
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && byte_cnt == 2'd3 && !(!cs_s && cs_d)) |=> (byte_cnt == 2'd3));
endmodule

bind spi_regfile_slave spi_regfile_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_d(cs_d), .sel(sel),
  .oe(miso_oe), .miso(miso), .byte_cnt(byte_cnt), .regs(regs)
);

// File: tb/test_spi_regfile_slave.sv
`timescale 1ns/1ps
module test_spi_regfile_slave;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso, miso_oe;
  logic [3:0] int_addr = '0;
  logic [7:0] int_rdata;
  logic [7:0] model [0:15];
  logic [7:0] txb [0:3];
  logic [7:0] rxb [0:3];
  logic oe_mid, oe_end;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_regfile_slave i_spi_regfile_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .miso_oe(miso_oe), .int_addr(int_addr), .int_rdata(int_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      #40;
      r[i] = miso;
      sck = 1'b1;
      #40;
      sck = 1'b0;
    end
  endtask

  task automatic run(input int n);
    logic [7:0] r;
    cs_n = 1'b0;
    #40;
    oe_mid = miso_oe;
    for (int k = 0; k < n; k++) begin
      xfer(txb[k], r);
      rxb[k] = r;
    end
    #40;
    cs_n = 1'b1;
    #80;
    oe_end = miso_oe;
  endtask

  task automatic cmp_all(input string req);
    for (int a = 0; a < 16; a++) begin
      int_addr = 4'(a);
      #40;
      chk(req, int_rdata, model[a]);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 16; a++) model[a] = 8'h00;
    #51;
    rst_n = 1'b1;
    #40;
    chk("R1 oe", {7'd0, miso_oe}, 8'h00);
    cmp_all("R1 reset regs");

    // R2 R3 R5 R6 R10: write sweep over every address, last one wraps
    for (int a = 0; a < 16; a++) begin
      logic [7:0] d1, d2;
      d1 = 8'((a * 37 + 11) & 255);
      d2 = 8'((a * 91 + 200) & 255);
      txb[0] = 8'(a); txb[1] = d1; txb[2] = d2;
      run(3);
      chk("R5 cmd byte", rxb[0], 8'hFF);
      chk("R6 data1 old value", rxb[1], model[a]);
      chk("R6 data2 old value", rxb[2], model[(a + 1) % 16]);
      chk("R8 oe during", {7'd0, oe_mid}, 8'h01);
      chk("R8 oe released", {7'd0, oe_end}, 8'h00);
      model[a] = d1;
      model[(a + 1) % 16] = d2;
    end
    cmp_all("R3 R2 R11 write result");

    // R4 R6 R7: reads with 0x4x and 0xCx, four bytes each
    for (int a = 0; a < 16; a++) begin
      txb[0] = ((a % 2) != 0 ? 8'hC0 : 8'h40) | 8'(a);
      txb[1] = 8'hA5; txb[2] = 8'h5A; txb[3] = 8'hFF;
      run(4);
      chk("R5 read cmd byte", rxb[0], 8'hFF);
      chk("R6 read data1", rxb[1], model[a]);
      chk("R6 read data2", rxb[2], model[(a + 1) % 16]);
      chk("R7 extra byte", rxb[3], 8'h00);
    end
    cmp_all("R4 reads leave regs");

    // R4: 0x8x is not a write
    txb[0] = 8'h85; txb[1] = 8'h11; txb[2] = 8'h22;
    run(3);
    chk("R4 0x85 data1", rxb[1], model[5]);
    cmp_all("R4 0x85 no write");

    // R3: single data byte touches only reg[a]
    txb[0] = 8'h07; txb[1] = 8'h3C;
    run(2);
    chk("R6 single data1", rxb[1], model[7]);
    model[7] = 8'h3C;
    cmp_all("R3 single byte write");

    // R7: fourth byte of a write is ignored
    txb[0] = 8'h09; txb[1] = 8'h01; txb[2] = 8'h02; txb[3] = 8'h03;
    run(4);
    chk("R7 write extra byte out", rxb[3], 8'h00);
    model[9] = 8'h01; model[10] = 8'h02;
    cmp_all("R7 extra byte no write");

    // R8: aborted byte then fresh transaction
    cs_n = 1'b0;
    #40;
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1; #40; sck = 1'b1; #40; sck = 1'b0;
    end
    #40;
    cs_n = 1'b1;
    #80;
    txb[0] = 8'h04; txb[1] = 8'h77; txb[2] = 8'h88;
    run(3);
    chk("R8 restart cmd byte", rxb[0], 8'hFF);
    chk("R8 restart data1", rxb[1], model[4]);
    model[4] = 8'h77; model[5] = 8'h88;
    cmp_all("R8 restart write");

    // R9: SCK activity while deselected
    for (int i = 0; i < 24; i++) begin
      mosi = i[0]; #40; sck = 1'b1; #40; sck = 1'b0;
      chk("R9 oe idle", {7'd0, miso_oe}, 8'h00);
    end
    cmp_all("R9 idle regs");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule